// File: doc/BRIEF.md
# Link Bootstrap Loader Controller

This block decides how a processor node comes out of reset. It samples a boot-select pin once, at the first clock edge after reset is released. If the pin is high, it releases the processor at once at a fixed address two bytes below the top of memory. That location normally holds a backward jump into ROM code. If the pin is low, the block waits on up to four byte-wide link receivers. It treats the first byte that arrives as a command/length byte.

A length of 2 to 255 starts a code download. The following bytes are stored from address zero upward through a 32-bit memory port with byte strobes. After the last one is stored, the processor is released at address zero.

Lengths 0 and 1 are debug commands for a node that has not booted yet:
- Length 0 writes one 32-bit word to memory.
- Length 1 reads one 32-bit word and returns it as four bytes on the transmit side of the requesting link.

After either command the block goes back to waiting for a new first byte. The link that delivers the first byte is owned by the transaction. Traffic on every other link is dropped until the transaction ends.

Top module: `lnk_boot_ctrl`

## Requirements
- R1: If `boot_rom_i` is high at the first clock edge after the internal reset release, `cpu_go_o` rises with `cpu_pc_o` = 2^ADDR_W − 2 (12'hFFE by default). From then on, link bytes cause no memory access and no transmit activity.
- R2: If `boot_rom_i` is low at that edge, `cpu_go_o` stays low while the block waits for link bytes. Later changes of `boot_rom_i` have no effect until the next reset.
- R3: With a first byte L in 2..255, the next L bytes of the owning link are written to byte addresses 0..L−1 in arrival order. Each write has exactly one strobe set, bit `addr[1:0]` of `mem_be_o`, and the byte is copied onto all four lanes of `mem_wdata_o`. Bytes at address L and above are untouched.
- R4: `cpu_go_o` rises with `cpu_pc_o` = 0 one cycle after the memory write of the L-th byte, and not earlier. Once high, `cpu_go_o` and `cpu_pc_o` hold until reset.
- R5: A first byte of 0 is a poke. It is followed by a 4-byte address and then a 4-byte data word, each least-significant byte first. The block issues exactly one write with all four strobes set, at the address with its two low bits cleared, and does not release the processor.
- R6: A first byte of 1 is a peek. It is followed by a 4-byte address, least-significant byte first. The block reads the word at the aligned address. It then sends the word as four bytes, least-significant byte first, on four consecutive cycles with `tx_vld_o` high.
- R7: In the waiting state, the link that delivers a byte is locked. If several deliver in the same cycle, the lowest index wins. Bytes on other links are dropped until the transaction ends, and a peek reply carries the locked link one-hot on `tx_sel_o`.
- R8: After a peek or poke completes, the lock is released and the next transaction may start on any link.
- R9: Bytes that arrive while a peek read or reply is in progress are dropped and do not start a new transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boot_rom_i | input | 1 | Boot-select pin, high to start from the top of memory |
| rx_vld_i | input | NLINK | Per-link received-byte strobe |
| rx_data_i | input | 8*NLINK | Per-link received byte, link i at bits [8i+7:8i] |
| tx_vld_o | output | 1 | Peek reply byte valid |
| tx_sel_o | output | NLINK | One-hot link that carries the reply byte |
| tx_data_o | output | 8 | Peek reply byte |
| mem_we_o | output | 1 | Memory write strobe |
| mem_re_o | output | 1 | Memory read strobe, data expected on the next cycle |
| mem_be_o | output | 4 | Byte lane strobes for a write |
| mem_addr_o | output | ADDR_W | Byte address |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, valid one cycle after `mem_re_o` |
| cpu_go_o | output | 1 | Processor release |
| cpu_pc_o | output | ADDR_W | Processor start address |

## Verification
The bench goes after the framing corners, where a slip of one byte makes every later transaction misread its fields.

Stray bytes are injected in three situations:
- on idle links during a download;
- on the locked link while a peek reply is being sent;
- on two links in the same cycle as the first byte.

A design that latched the wrong link, or took a stray byte as a new command, would misplace downloaded bytes, reply on the wrong link, or garble the next peek.

The release timing is checked to the cycle. A design that counted the length off by one would start the processor before the last byte lands, or would wait one byte too long. The 255-byte limit and the byte just past the image are also checked.

// File: rtl/lnkboot_pkg.sv
package lnkboot_pkg;
  localparam int WORD_W = 32;
  localparam int WBYTES = WORD_W / 8;
  localparam int BSEL_W = $clog2(WBYTES);
  localparam int LEN_W  = 8;

  localparam logic [LEN_W-1:0] LEN_POKE = 8'd0;
  localparam logic [LEN_W-1:0] LEN_PEEK = 8'd1;

  typedef enum logic [3:0] {
    ST_INIT,
    ST_IDLE,
    ST_LOAD,
    ST_PK_ADR,
    ST_PK_DAT,
    ST_PE_ADR,
    ST_PE_RD,
    ST_PE_LD,
    ST_PE_TX,
    ST_GO,
    ST_RUN
  } bst_e;
endpackage

// File: rtl/lnkboot_sel.sv
module lnkboot_sel #(
  parameter int NLINK = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               idle_i,
  input  logic [NLINK-1:0]   rx_vld_i,
  input  logic [NLINK*8-1:0] rx_data_i,
  output logic               hit_o,
  output logic [7:0]         byte_o,
  output logic [NLINK-1:0]   lock_o
);
  logic [NLINK-1:0] pick;
  logic [NLINK-1:0] cand;
  logic [NLINK-1:0] lock_q;
  logic             lock_en;

  // fixed priority: lowest link index wins a tie
  always_comb begin
    pick = '0;
    for (int i = 0; i < NLINK; i++) begin
      if (rx_vld_i[i] && (pick == '0)) pick[i] = 1'b1;
    end
  end

  assign cand    = idle_i ? pick : (lock_q & rx_vld_i);
  assign hit_o   = |cand;
  assign lock_en = idle_i && hit_o;

  always_comb begin
    byte_o = '0;
    for (int i = 0; i < NLINK; i++) begin
      if (cand[i]) byte_o = byte_o | rx_data_i[i*8 +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= '0;
    end else if (lock_en) begin
      lock_q <= pick;
    end
  end

  assign lock_o = lock_q;

  p_lock_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lock_q));

  p_lock_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !idle_i |=> $stable(lock_q));
endmodule

// File: rtl/lnkboot_acc.sv
module lnkboot_acc
  import lnkboot_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_i,
  input  logic [7:0]        byte_i,
  output logic [WORD_W-1:0] word_nxt_o
);
  logic [WORD_W-1:0] acc_q;

  // bytes arrive least-significant first, so new bytes enter at the top
  assign word_nxt_o = {byte_i, acc_q[WORD_W-1:8]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (shift_i) begin
      acc_q <= word_nxt_o;
    end
  end
endmodule

// File: rtl/lnkboot_ser.sv
module lnkboot_ser
  import lnkboot_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              tx_vld_o,
  output logic [7:0]        tx_byte_o,
  output logic              last_o
);
  localparam int NW = $clog2(WBYTES + 1);

  logic [WORD_W-1:0] sh_q, sh_d;
  logic [NW-1:0]     left_q, left_d;
  logic              sh_en;

  assign tx_vld_o  = (left_q != '0);
  assign tx_byte_o = sh_q[7:0];
  assign last_o    = (left_q == NW'(1));
  assign sh_en     = load_i || tx_vld_o;

  always_comb begin
    if (load_i) begin
      sh_d   = word_i;
      left_d = NW'(WBYTES);
    end else begin
      sh_d   = {8'h00, sh_q[WORD_W-1:8]};
      left_d = left_q - NW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      left_q <= '0;
    end else if (sh_en) begin
      sh_q   <= sh_d;
      left_q <= left_d;
    end
  end

  p_no_reload_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> !tx_vld_o);

  p_reply_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (left_q == NW'(WBYTES)));
endmodule

// File: rtl/lnk_boot_ctrl.sv
module lnk_boot_ctrl
  import lnkboot_pkg::*;
#(
  parameter int NLINK  = 4,
  parameter int ADDR_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               boot_rom_i,
  input  logic [NLINK-1:0]   rx_vld_i,
  input  logic [NLINK*8-1:0] rx_data_i,
  output logic               tx_vld_o,
  output logic [NLINK-1:0]   tx_sel_o,
  output logic [7:0]         tx_data_o,
  output logic               mem_we_o,
  output logic               mem_re_o,
  output logic [WBYTES-1:0]  mem_be_o,
  output logic [ADDR_W-1:0]  mem_addr_o,
  output logic [WORD_W-1:0]  mem_wdata_o,
  input  logic [WORD_W-1:0]  mem_rdata_i,
  output logic               cpu_go_o,
  output logic [ADDR_W-1:0]  cpu_pc_o
);
  localparam int                 WA_W   = ADDR_W - BSEL_W;
  localparam logic [ADDR_W-1:0] ROM_PC = {ADDR_W{1'b1}} - ADDR_W'(1);
  localparam logic [LEN_W-1:0]  WLAST  = LEN_W'(WBYTES - 1);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rs_q;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign srst_n = rs_q[1];

  // state and datapath registers
  bst_e              st_q, st_d;
  logic [LEN_W-1:0]  cnt_q, cnt_d, cnt_inc;
  logic [LEN_W-1:0]  len_q, len_d;
  logic [WA_W-1:0]   adr_q, adr_d;
  logic              wr_vld_q, wr_vld_d;
  logic [ADDR_W-1:0] wr_adr_q, wr_adr_d;
  logic [WBYTES-1:0] wr_be_q, wr_be_d;
  logic [WORD_W-1:0] wr_dat_q, wr_dat_d;
  logic              go_q, go_d;
  logic [ADDR_W-1:0] pc_q, pc_d;

  logic              idle, hit, shift, ser_load, ser_last;
  logic [7:0]        rx_byte;
  logic [NLINK-1:0]  lock;
  logic [WORD_W-1:0] word_nxt;

  assign idle    = (st_q == ST_IDLE);
  assign cnt_inc = cnt_q + LEN_W'(1);

  lnkboot_sel #(.NLINK(NLINK)) u_sel (
    .clk       (clk),
    .rst_n     (srst_n),
    .idle_i    (idle),
    .rx_vld_i  (rx_vld_i),
    .rx_data_i (rx_data_i),
    .hit_o     (hit),
    .byte_o    (rx_byte),
    .lock_o    (lock)
  );

  lnkboot_acc u_acc (
    .clk        (clk),
    .rst_n      (srst_n),
    .shift_i    (shift),
    .byte_i     (rx_byte),
    .word_nxt_o (word_nxt)
  );

  lnkboot_ser u_ser (
    .clk       (clk),
    .rst_n     (srst_n),
    .load_i    (ser_load),
    .word_i    (mem_rdata_i),
    .tx_vld_o  (tx_vld_o),
    .tx_byte_o (tx_data_o),
    .last_o    (ser_last)
  );

  // next-state logic
  always_comb begin
    st_d     = st_q;
    cnt_d    = cnt_q;
    len_d    = len_q;
    adr_d    = adr_q;
    wr_vld_d = 1'b0;
    wr_adr_d = wr_adr_q;
    wr_be_d  = wr_be_q;
    wr_dat_d = wr_dat_q;
    go_d     = go_q;
    pc_d     = pc_q;
    shift    = 1'b0;
    ser_load = 1'b0;
    unique case (st_q)
      ST_INIT: begin
        if (boot_rom_i) begin
          st_d = ST_RUN;
          go_d = 1'b1;
          pc_d = ROM_PC;
        end else begin
          st_d = ST_IDLE;
        end
      end
      ST_IDLE: begin
        if (hit) begin
          len_d = rx_byte;
          cnt_d = '0;
          if (rx_byte == LEN_POKE)      st_d = ST_PK_ADR;
          else if (rx_byte == LEN_PEEK) st_d = ST_PE_ADR;
          else                          st_d = ST_LOAD;
        end
      end
      ST_LOAD: begin
        if (hit) begin
          wr_vld_d = 1'b1;
          wr_adr_d = ADDR_W'(cnt_q);
          wr_be_d  = WBYTES'(1) << cnt_q[BSEL_W-1:0];
          wr_dat_d = {WBYTES{rx_byte}};
          cnt_d    = cnt_inc;
          if (cnt_inc == len_q) st_d = ST_GO;
        end
      end
      ST_PK_ADR, ST_PE_ADR: begin
        if (hit) begin
          shift = 1'b1;
          cnt_d = cnt_inc;
          if (cnt_q == WLAST) begin
            adr_d = word_nxt[ADDR_W-1:BSEL_W];
            cnt_d = '0;
            st_d  = (st_q == ST_PK_ADR) ? ST_PK_DAT : ST_PE_RD;
          end
        end
      end
      ST_PK_DAT: begin
        if (hit) begin
          shift = 1'b1;
          cnt_d = cnt_inc;
          if (cnt_q == WLAST) begin
            wr_vld_d = 1'b1;
            wr_adr_d = {adr_q, BSEL_W'(0)};
            wr_be_d  = '1;
            wr_dat_d = word_nxt;
            st_d     = ST_IDLE;
          end
        end
      end
      ST_PE_RD: st_d = ST_PE_LD;
      ST_PE_LD: begin
        ser_load = 1'b1;
        st_d     = ST_PE_TX;
      end
      ST_PE_TX: begin
        if (ser_last) st_d = ST_IDLE;
      end
      ST_GO: begin
        go_d = 1'b1;
        pc_d = '0;
        st_d = ST_RUN;
      end
      ST_RUN: st_d = ST_RUN;
      default: st_d = ST_INIT;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      st_q     <= ST_INIT;
      cnt_q    <= '0;
      len_q    <= '0;
      adr_q    <= '0;
      wr_vld_q <= 1'b0;
      wr_adr_q <= '0;
      wr_be_q  <= '0;
      wr_dat_q <= '0;
      go_q     <= 1'b0;
      pc_q     <= '0;
    end else begin
      st_q     <= st_d;
      cnt_q    <= cnt_d;
      len_q    <= len_d;
      adr_q    <= adr_d;
      wr_vld_q <= wr_vld_d;
      wr_adr_q <= wr_adr_d;
      wr_be_q  <= wr_be_d;
      wr_dat_q <= wr_dat_d;
      go_q     <= go_d;
      pc_q     <= pc_d;
    end
  end

  // outputs
  assign mem_we_o    = wr_vld_q;
  assign mem_re_o    = (st_q == ST_PE_RD);
  assign mem_be_o    = wr_be_q;
  assign mem_wdata_o = wr_dat_q;
  assign mem_addr_o  = wr_vld_q ? wr_adr_q : {adr_q, BSEL_W'(0)};
  assign tx_sel_o    = tx_vld_o ? lock : '0;
  assign cpu_go_o    = go_q;
  assign cpu_pc_o    = pc_q;

  p_go_sticky_r4: assert property (@(posedge clk) disable iff (!srst_n)
    cpu_go_o |=> cpu_go_o);

  p_pc_hold_r4: assert property (@(posedge clk) disable iff (!srst_n)
    cpu_go_o |=> $stable(cpu_pc_o));

  p_go_after_write_r4: assert property (@(posedge clk) disable iff (!srst_n)
    ($rose(cpu_go_o) && (cpu_pc_o != ROM_PC)) |-> $past(mem_we_o));

  p_quiet_when_run_r1: assert property (@(posedge clk) disable iff (!srst_n)
    cpu_go_o |-> (!mem_we_o && !mem_re_o && !tx_vld_o));

  p_rw_excl_r5: assert property (@(posedge clk) disable iff (!srst_n)
    !(mem_we_o && mem_re_o));

  p_tx_in_reply_r6: assert property (@(posedge clk) disable iff (!srst_n)
    tx_vld_o |-> (st_q == ST_PE_TX));

  p_tx_onehot_r7: assert property (@(posedge clk) disable iff (!srst_n)
    tx_vld_o |-> $onehot(tx_sel_o));
endmodule

// File: tb/sim_lnk_boot_ctrl.sv
module sim_lnk_boot_ctrl;
  localparam int NLINK  = 4;
  localparam int ADDR_W = 12;
  localparam int MSZ    = 1 << ADDR_W;

  logic               clk;
  logic               rst_n;
  logic               boot_rom;
  logic [NLINK-1:0]   rx_vld;
  logic [NLINK*8-1:0] rx_data;
  logic               tx_vld;
  logic [NLINK-1:0]   tx_sel;
  logic [7:0]         tx_data;
  logic               mem_we, mem_re;
  logic [3:0]         mem_be;
  logic [ADDR_W-1:0]  mem_addr;
  logic [31:0]        mem_wdata, mem_rdata;
  logic               cpu_go;
  logic [ADDR_W-1:0]  cpu_pc;

  lnk_boot_ctrl #(.NLINK(NLINK), .ADDR_W(ADDR_W)) u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .boot_rom_i  (boot_rom),
    .rx_vld_i    (rx_vld),
    .rx_data_i   (rx_data),
    .tx_vld_o    (tx_vld),
    .tx_sel_o    (tx_sel),
    .tx_data_o   (tx_data),
    .mem_we_o    (mem_we),
    .mem_re_o    (mem_re),
    .mem_be_o    (mem_be),
    .mem_addr_o  (mem_addr),
    .mem_wdata_o (mem_wdata),
    .mem_rdata_i (mem_rdata),
    .cpu_go_o    (cpu_go),
    .cpu_pc_o    (cpu_pc)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // behavioural memory
  logic [7:0] mem [MSZ];
  int nwr;
  initial begin
    for (int i = 0; i < MSZ; i++) mem[i] = 8'hEE;
    nwr = 0;
  end
  always @(posedge clk) begin
    if (mem_we) begin
      nwr <= nwr + 1;
      for (int b = 0; b < 4; b++)
        if (mem_be[b]) mem[{mem_addr[ADDR_W-1:2], 2'(b)}] <= mem_wdata[b*8 +: 8];
    end
    if (mem_re)
      mem_rdata <= {mem[{mem_addr[ADDR_W-1:2], 2'd3}], mem[{mem_addr[ADDR_W-1:2], 2'd2}],
                    mem[{mem_addr[ADDR_W-1:2], 2'd1}], mem[{mem_addr[ADDR_W-1:2], 2'd0}]};
  end

  function automatic logic [31:0] mword(logic [ADDR_W-1:0] a);
    return {mem[{a[ADDR_W-1:2], 2'd3}], mem[{a[ADDR_W-1:2], 2'd2}],
            mem[{a[ADDR_W-1:2], 2'd1}], mem[{a[ADDR_W-1:2], 2'd0}]};
  endfunction

  // reply capture
  int         ncap;
  logic [7:0] cap [8];
  logic [NLINK-1:0] capsel [8];
  always @(negedge clk) begin
    if (tx_vld) begin
      if (ncap < 8) begin
        cap[ncap]    = tx_data;
        capsel[ncap] = tx_sel;
      end
      ncap = ncap + 1;
    end
  end

  int total, bad;
  initial begin total = 0; bad = 0; ncap = 0; end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send_byte(int l, logic [7:0] b);
    rx_vld          = '0;
    rx_vld[l]       = 1'b1;
    rx_data[l*8 +: 8] = b;
    @(negedge clk);
    rx_vld = '0;
  endtask

  task automatic send2(int la, logic [7:0] ba, int lb, logic [7:0] bb);
    rx_vld             = '0;
    rx_vld[la]         = 1'b1;
    rx_vld[lb]         = 1'b1;
    rx_data[la*8 +: 8] = ba;
    rx_data[lb*8 +: 8] = bb;
    @(negedge clk);
    rx_vld = '0;
  endtask

  task automatic send_word(int l, logic [31:0] w);
    for (int i = 0; i < 4; i++) send_byte(l, w[i*8 +: 8]);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic poke(int l, logic [ADDR_W-1:0] a, logic [31:0] d);
    send_byte(l, 8'd0);
    send_word(l, 32'(a));
    send_word(l, d);
    idle(2);
  endtask

  task automatic peek(int l, logic [ADDR_W-1:0] a);
    ncap = 0;
    send_byte(l, 8'd1);
    send_word(l, 32'(a));
    idle(8);
  endtask

  function automatic logic [31:0] capword();
    return {cap[3], cap[2], cap[1], cap[0]};
  endfunction

  task automatic do_reset(logic pin);
    rst_n    = 1'b0;
    boot_rom = pin;
    idle(3);
    rst_n = 1'b1;
    idle(6);
  endtask

  // link, poke address, peek address, data; peek goes on link+1
  localparam logic [57:0] VEC [6] = '{
    {2'd0, 12'h100, 12'h100, 32'h11223344},
    {2'd1, 12'h205, 12'h206, 32'hCAFEF00D},
    {2'd2, 12'h3FC, 12'h3FF, 32'h00000000},
    {2'd3, 12'hFFC, 12'hFFC, 32'hFFFFFFFF},
    {2'd1, 12'h010, 12'h010, 32'h80000001},
    {2'd3, 12'h100, 12'h102, 32'hA5A55A5A}
  };

  initial begin
    rx_vld  = '0;
    rx_data = '0;
    rst_n   = 1'b0;
    boot_rom = 1'b1;
    @(negedge clk);
    idle(2);
    // reset state
    chk("R4 reset go", 32'(cpu_go), 32'd0);
    chk("R3 reset we", 32'(mem_we), 32'd0);
    chk("R6 reset tx", 32'(tx_vld), 32'd0);
    rst_n = 1'b1;
    idle(6);
    // R1: boot from top of memory
    chk("R1 rom go", 32'(cpu_go), 32'd1);
    chk("R1 rom pc", 32'(cpu_pc), 32'hFFE);
    boot_rom = 1'b0;
    ncap = 0;
    send_byte(0, 8'd5);
    send_word(0, 32'h04030201);
    send_byte(1, 8'd1);
    send_word(1, 32'h00000100);
    idle(8);
    chk("R1 rom no writes", 32'(nwr), 32'd0);
    chk("R1 rom no reply", 32'(ncap), 32'd0);
    chk("R1 rom pc kept", 32'(cpu_pc), 32'hFFE);

    // R2: link boot, pin later ignored
    do_reset(1'b0);
    boot_rom = 1'b1;
    idle(4);
    chk("R2 waits", 32'(cpu_go), 32'd0);

    // table of poke then peek on the next link
    for (int v = 0; v < 6; v++) begin
      automatic int pl = int'(VEC[v][57:56]);
      automatic int ql = (pl + 1) % NLINK;
      automatic logic [ADDR_W-1:0] pa = VEC[v][55:44];
      automatic logic [ADDR_W-1:0] qa = VEC[v][43:32];
      automatic logic [31:0] d = VEC[v][31:0];
      automatic int w0 = nwr;
      poke(pl, pa, d);
      chk("R5 one write", 32'(nwr - w0), 32'd1);
      chk("R5 word stored", mword(pa), d);
      peek(ql, qa);
      chk("R6 reply count", 32'(ncap), 32'd4);
      chk("R6 reply word", capword(), d);
      chk("R8 reply link", 32'(capsel[0] | capsel[3]), 32'(1 << ql));
    end
    chk("R5 no start", 32'(cpu_go), 32'd0);

    // R7: two links at once, lowest wins; other link's bytes dropped
    ncap = 0;
    send2(3, 8'd1, 1, 8'd1);
    send2(1, 8'h04, 3, 8'h00);
    send2(1, 8'h02, 3, 8'h00);
    send2(1, 8'h00, 3, 8'h01);
    send2(1, 8'h00, 3, 8'h00);
    idle(8);
    chk("R7 tie reply count", 32'(ncap), 32'd4);
    chk("R7 tie reply word", capword(), 32'hCAFEF00D);
    chk("R7 tie reply link", 32'(capsel[0]), 32'b0010);

    // R9: bytes during read and reply are dropped
    begin
      automatic int w0 = nwr;
      ncap = 0;
      send_byte(2, 8'd1);
      send_word(2, 32'h00000100);
      send_byte(2, 8'h00);
      send_byte(0, 8'h01);
      send_byte(2, 8'h01);
      idle(6);
      chk("R9 reply word", capword(), 32'hA5A55A5A);
      chk("R9 reply link", 32'(capsel[3]), 32'b0100);
      peek(0, 12'h204);
      chk("R9 next peek", capword(), 32'hCAFEF00D);
      chk("R9 no writes", 32'(nwr - w0), 32'd0);
    end

    // R3/R4: download of 11 bytes on link 2 with interference
    poke(0, 12'h008, 32'hDEADBEEF);
    begin
      automatic int w0 = nwr;
      send_byte(2, 8'd11);
      for (int i = 0; i < 10; i++) begin
        if (i == 5) send_byte(0, 8'h77);
        if (i == 6) send2(2, 8'(8'hA0 + i * 7), 1, 8'h55);
        else        send_byte(2, 8'(8'hA0 + i * 7));
      end
      idle(3);
      chk("R4 not early", 32'(cpu_go), 32'd0);
      chk("R7 ignored bytes", 32'(nwr - w0), 32'd10);
      send_byte(2, 8'(8'hA0 + 10 * 7));
      chk("R4 last write", 32'(mem_we), 32'd1);
      chk("R4 go after write", 32'(cpu_go), 32'd0);
      @(negedge clk);
      chk("R4 go", 32'(cpu_go), 32'd1);
      chk("R4 pc zero", 32'(cpu_pc), 32'd0);
      begin
        automatic int errs = 0;
        for (int i = 0; i < 11; i++)
          if (mem[i] !== 8'(8'hA0 + i * 7)) errs++;
        chk("R3 image bytes", 32'(errs), 32'd0);
      end
      chk("R3 byte past image", 32'(mem[11]), 32'hDE);
    end

    // R3/R4: longest image
    boot_rom = 1'b0;
    do_reset(1'b0);
    send_byte(3, 8'd255);
    for (int i = 0; i < 255; i++) send_byte(3, 8'(i) ^ 8'h5A);
    idle(2);
    chk("R4 go 255", 32'(cpu_go), 32'd1);
    chk("R4 pc 255", 32'(cpu_pc), 32'd0);
    begin
      automatic int errs = 0;
      for (int i = 0; i < 255; i++)
        if (mem[i] !== (8'(i) ^ 8'h5A)) errs++;
      chk("R3 image 255", 32'(errs), 32'd0);
    end
    chk("R3 byte 255 untouched", 32'(mem[255]), 32'hEE);
    begin
      automatic int w0 = nwr;
      send_byte(3, 8'd4);
      send_word(3, 32'h01020304);
      idle(4);
      chk("R4 stays running", 32'(nwr - w0), 32'd0);
      chk("R4 go held", 32'(cpu_go), 32'd1);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule